// File: doc/BRIEF.md
# Memory card transaction tracker

This block sits behind a bus symbol decoder for a three-wire synchronous memory card. It does not look at the wires. Instead it receives three kinds of events: line symbols (reset with clock pulse, interrupt, start, stop), data bits with the I/O level seen during one card clock, and assembled bytes. From these events it follows each transaction through its phases: answer-to-reset, command entry, a pending data phase, outgoing data and internal processing.

A command entry is three bytes, taken in order as control, address and data. Once the third byte arrives, the tracker reports the fields and looks up the response style from the control byte. The style is open-ended output, exactly four output bytes, or internal processing. The tracker does not commit to that response phase at the stop symbol. It waits for the first data bit after the stop. During processing it counts card clocks until the I/O line is seen high.

A transaction can finish in two ways: it reaches its natural end, or a new start, reset or interrupt cuts it off. Either way the tracker raises a one-cycle completion strobe. The strobe carries the phase that ended and, for processing, the clock count.

Top module: `card_txn_tracker`

## Requirements
- R1: A reset symbol (sym_kind 0) enters phase ATR (phase 1). Once 4 bytes have arrived there, txn_done pulses with txn_phase 1 and phase returns to IDLE (0). An interrupt symbol (sym_kind 1) leads to IDLE and never to ATR.
- R2: A start symbol (sym_kind 2) enters phase CMD (2). The next three bytes are latched as cmd_ctrl, cmd_addr and cmd_data, in that order. On the third byte, cmd_done pulses with the fields valid and phase goes to IDLE.
- R3: The control byte picks the response style. 0x30 gives open-ended output. 0x31 and 0x34 give fixed output of 4 bytes. 0x33, 0x38, 0x39 and 0x3C give processing. Any other value sets cmd_unknown and gives open-ended output.
- R4: A stop symbol (sym_kind 3) moves to phase PEND (3) from any phase except OUT (4) and PROC (5). In OUT and PROC a stop is ignored and the phase does not change.
- R5: The first bit event in PEND picks the next phase. That is PROC for a processing command and OUT otherwise, which includes the case where no command came before.
- R6: In OUT with a fixed-length command, the 4th byte pulses txn_done with txn_phase 4 and phase returns to IDLE. Open-ended output stays in OUT whatever the number of bytes.
- R7: In processing, every bit event counts one clock, including the bit that entered PROC. A bit with bit_io high ends the phase: txn_done pulses with txn_phase 5, proc_cycles shows the count, and phase goes to IDLE.
- R8: The processing count saturates at 2^CNT_W-1 (65535 by default) and does not wrap.
- R9: A reset, interrupt or start symbol that arrives while phase is not IDLE pulses txn_done with txn_phase equal to the old phase, in the same cycle as the new phase is entered. A flushed PROC reports the clocks counted so far.
- R10: When events fall in the same cycle, a symbol takes priority over a bit, and a bit over a byte. The lower-priority events in that cycle are dropped.
- R11: After reset, phase is IDLE, all strobes are low, and the command fields and proc_cycles are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Line symbol event |
| sym_kind | input | 2 | 0 reset with clock, 1 interrupt, 2 start, 3 stop |
| bit_valid | input | 1 | One card clock with a data bit |
| bit_io | input | 1 | I/O level of that bit |
| byte_valid | input | 1 | Assembled byte event |
| byte_data | input | DATA_W | Byte value |
| phase | output | 3 | Current phase: 0 IDLE, 1 ATR, 2 CMD, 3 PEND, 4 OUT, 5 PROC |
| cmd_ctrl | output | DATA_W | Control byte of the last command |
| cmd_addr | output | DATA_W | Address byte of the last command |
| cmd_data | output | DATA_W | Data byte of the last command |
| cmd_unknown | output | 1 | The last control byte was not recognised |
| cmd_done | output | 1 | One-cycle strobe: command entry decoded |
| txn_done | output | 1 | One-cycle strobe: a transaction phase ended |
| txn_phase | output | 3 | Phase that ended, valid with txn_done |
| proc_cycles | output | CNT_W | Clock count of the last processing phase |

## Verification
The hardest case is a flush that happens in the same cycle as a new phase is entered. A start symbol can cut short an open-ended output stream. A start can also interrupt processing after a few clocks. An interrupt can land in the middle of a command entry. In each case one edge both closes the old transaction and opens the new phase. The scoreboard pops the expected completion (phase, and for processing the clock count) when the strobe appears. The bench also checks that phase already shows the new phase after that same edge.

// File: rtl/cardtrk_pkg.sv
package cardtrk_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ATR  = 3'd1,
    PH_CMD  = 3'd2,
    PH_PEND = 3'd3,
    PH_OUT  = 3'd4,
    PH_PROC = 3'd5
  } phase_t;

  typedef enum logic [1:0] {
    SYM_RESET = 2'd0,
    SYM_INTR  = 2'd1,
    SYM_START = 2'd2,
    SYM_STOP  = 2'd3
  } sym_t;

  typedef enum logic [1:0] {
    RSP_OPEN  = 2'd0,
    RSP_FIXED = 2'd1,
    RSP_PROC  = 2'd2
  } rsp_t;

endpackage

// File: rtl/cardtrk_cmd_decode.sv
module cardtrk_cmd_decode
  import cardtrk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] ctrl,
  output rsp_t              rsp,
  output logic              unknown
);

  localparam logic [DATA_W-1:0] OP_RD_MAIN  = DATA_W'(8'h30);
  localparam logic [DATA_W-1:0] OP_RD_SEC   = DATA_W'(8'h31);
  localparam logic [DATA_W-1:0] OP_CMP_VER  = DATA_W'(8'h33);
  localparam logic [DATA_W-1:0] OP_RD_PROT  = DATA_W'(8'h34);
  localparam logic [DATA_W-1:0] OP_WR_MAIN  = DATA_W'(8'h38);
  localparam logic [DATA_W-1:0] OP_WR_SEC   = DATA_W'(8'h39);
  localparam logic [DATA_W-1:0] OP_WR_PROT  = DATA_W'(8'h3C);

  always_comb begin
    unknown = 1'b0;
    rsp     = RSP_OPEN;
    case (ctrl)
      OP_RD_MAIN:                         rsp = RSP_OPEN;
      OP_RD_SEC, OP_RD_PROT:              rsp = RSP_FIXED;
      OP_CMP_VER, OP_WR_MAIN,
      OP_WR_SEC, OP_WR_PROT:              rsp = RSP_PROC;
      default: begin
        rsp     = RSP_OPEN;
        unknown = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/cardtrk_satcnt.sv
module cardtrk_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load_one,
  input  logic         step,
  output logic [W-1:0] q,
  output logic [W-1:0] q_inc
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  assign q_inc = (q == MAXV) ? MAXV : q + W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (load_one) q <= W'(1);
    else if (step) q <= q_inc;
  end

  AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (rst)
    (q == MAXV && step && !clr && !load_one) |=> (q == MAXV)); // R8

endmodule

// File: rtl/card_txn_tracker.sv
module card_txn_tracker
  import cardtrk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int ATR_LEN   = 4,
  parameter int CMD_LEN   = 3,
  parameter int FIXED_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_valid,
  input  logic [1:0]        sym_kind,
  input  logic              bit_valid,
  input  logic              bit_io,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic [2:0]        phase,
  output logic [DATA_W-1:0] cmd_ctrl,
  output logic [DATA_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_unknown,
  output logic              cmd_done,
  output logic              txn_done,
  output logic [2:0]        txn_phase,
  output logic [CNT_W-1:0]  proc_cycles
);

  localparam int MAX_LEN_A = (ATR_LEN > FIXED_LEN) ? ATR_LEN : FIXED_LEN;
  localparam int MAX_LEN   = (MAX_LEN_A > CMD_LEN) ? MAX_LEN_A : CMD_LEN;
  localparam int BC_W      = $clog2(MAX_LEN + 1);

  phase_t phase_q, ph_n;
  rsp_t   rsp_q, rsp_n, dec_rsp;
  logic   dec_unknown;

  logic [BC_W-1:0]  bc_q, bc_inc;
  logic [CNT_W-1:0] pc_q, pc_inc;
  logic             bc_clr, bc_step;
  logic             pc_clr, pc_load, pc_step;

  logic             tdone_n, cdone_n, cap_n;
  phase_t           tph_n;
  logic [CNT_W-1:0] cap_val;
  logic             wr_ctrl, wr_addr, wr_data;

  logic sym_fire, bit_fire, byte_fire;
  logic in_stream;

  // Event priority: symbol, then bit, then byte
  assign sym_fire  = sym_valid;
  assign bit_fire  = bit_valid & ~sym_valid;
  assign byte_fire = byte_valid & ~sym_valid & ~bit_valid;
  assign in_stream = (phase_q == PH_OUT) || (phase_q == PH_PROC);

  cardtrk_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .ctrl    (cmd_ctrl),
    .rsp     (dec_rsp),
    .unknown (dec_unknown)
  );

  cardtrk_satcnt #(.W(BC_W)) u_bytecnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (bc_clr),
    .load_one (1'b0),
    .step     (bc_step),
    .q        (bc_q),
    .q_inc    (bc_inc)
  );

  cardtrk_satcnt #(.W(CNT_W)) u_proccnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (pc_clr),
    .load_one (pc_load),
    .step     (pc_step),
    .q        (pc_q),
    .q_inc    (pc_inc)
  );

  always_comb begin
    ph_n    = phase_q;
    rsp_n   = rsp_q;
    bc_clr  = 1'b0;
    bc_step = 1'b0;
    pc_clr  = 1'b0;
    pc_load = 1'b0;
    pc_step = 1'b0;
    tdone_n = 1'b0;
    tph_n   = phase_q;
    cap_n   = 1'b0;
    cap_val = pc_q;
    cdone_n = 1'b0;
    wr_ctrl = 1'b0;
    wr_addr = 1'b0;
    wr_data = 1'b0;

    if (sym_fire) begin
      if (sym_kind != SYM_STOP) begin
        // flush whatever is open, then enter the new phase
        tdone_n = (phase_q != PH_IDLE);
        cap_n   = (phase_q == PH_PROC);
        bc_clr  = 1'b1;
        pc_clr  = 1'b1;
        case (sym_kind)
          SYM_RESET: ph_n = PH_ATR;
          SYM_START: begin
            ph_n  = PH_CMD;
            rsp_n = RSP_OPEN;
          end
          default:   ph_n = PH_IDLE;
        endcase
      end else if (!in_stream) begin
        ph_n   = PH_PEND;
        bc_clr = 1'b1;
      end
    end else if (bit_fire) begin
      if (phase_q == PH_PEND) begin
        case (rsp_q)
          RSP_PROC: begin
            ph_n    = PH_PROC;
            pc_load = 1'b1;
            if (bit_io) begin
              tdone_n = 1'b1;
              tph_n   = PH_PROC;
              cap_n   = 1'b1;
              cap_val = CNT_W'(1);
              ph_n    = PH_IDLE;
            end
          end
          default: ph_n = PH_OUT;
        endcase
      end else if (phase_q == PH_PROC) begin
        pc_step = 1'b1;
        if (bit_io) begin
          tdone_n = 1'b1;
          cap_n   = 1'b1;
          cap_val = pc_inc;
          ph_n    = PH_IDLE;
        end
      end
    end else if (byte_fire) begin
      case (phase_q)
        PH_ATR: begin
          bc_step = 1'b1;
          if (bc_inc == BC_W'(ATR_LEN)) begin
            tdone_n = 1'b1;
            ph_n    = PH_IDLE;
          end
        end
        PH_CMD: begin
          bc_step = 1'b1;
          if (bc_q == BC_W'(0)) wr_ctrl = 1'b1;
          else if (bc_q == BC_W'(1)) wr_addr = 1'b1;
          else wr_data = 1'b1;
          if (bc_inc == BC_W'(CMD_LEN)) begin
            cdone_n = 1'b1;
            rsp_n   = dec_rsp;
            ph_n    = PH_IDLE;
          end
        end
        PH_OUT: begin
          bc_step = 1'b1;
          if (rsp_q == RSP_FIXED && bc_inc == BC_W'(FIXED_LEN)) begin
            tdone_n = 1'b1;
            ph_n    = PH_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      rsp_q       <= RSP_OPEN;
      cmd_ctrl    <= '0;
      cmd_addr    <= '0;
      cmd_data    <= '0;
      cmd_unknown <= 1'b0;
      cmd_done    <= 1'b0;
      txn_done    <= 1'b0;
      txn_phase   <= PH_IDLE;
      proc_cycles <= '0;
    end else begin
      phase_q   <= ph_n;
      rsp_q     <= rsp_n;
      cmd_done  <= cdone_n;
      txn_done  <= tdone_n;
      txn_phase <= tph_n;
      if (wr_ctrl) cmd_ctrl <= byte_data;
      if (wr_addr) cmd_addr <= byte_data;
      if (wr_data) cmd_data <= byte_data;
      if (cdone_n) cmd_unknown <= dec_unknown;
      if (cap_n) proc_cycles <= cap_val;
    end
  end

  assign phase = phase_q;

  AST_ATR_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_kind == SYM_RESET) |=> (phase == PH_ATR)); // R1

  AST_CMD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_kind == SYM_START) |=> (phase == PH_CMD)); // R2

  AST_STOP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_kind == SYM_STOP &&
     (phase == PH_OUT || phase == PH_PROC)) |=> $stable(phase)); // R4

  AST_PROC_END: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PROC && bit_valid && !sym_valid && bit_io)
      |=> (txn_done && phase == PH_IDLE && txn_phase == PH_PROC)); // R7

  AST_FLUSH_STROBE: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_kind != SYM_STOP && phase != PH_IDLE)
      |=> (txn_done && txn_phase == $past(phase))); // R9

  AST_ONE_EVENT_CLASS: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && byte_valid && phase == PH_IDLE && sym_kind == SYM_INTR)
      |=> (!cmd_done && !txn_done)); // R10

endmodule

// File: tb/sim_card_txn_tracker.sv
module sim_card_txn_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sym_valid = 1'b0;
  logic [1:0]  sym_kind = 2'd0;
  logic        bit_valid = 1'b0;
  logic        bit_io = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'd0;
  logic [2:0]  phase;
  logic [7:0]  cmd_ctrl, cmd_addr, cmd_data;
  logic        cmd_unknown, cmd_done, txn_done;
  logic [2:0]  txn_phase;
  logic [CNT_W-1:0] proc_cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // scoreboard queues
  logic [2:0]  q_tph[$];
  logic [15:0] q_tcyc[$];
  string       q_ttag[$];
  logic [24:0] q_cmd[$];
  string       q_ctag[$];

  card_txn_tracker u0 (
    .clk(clk), .rst(rst),
    .sym_valid(sym_valid), .sym_kind(sym_kind),
    .bit_valid(bit_valid), .bit_io(bit_io),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .phase(phase), .cmd_ctrl(cmd_ctrl), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_unknown(cmd_unknown), .cmd_done(cmd_done),
    .txn_done(txn_done), .txn_phase(txn_phase), .proc_cycles(proc_cycles)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic exp_txn(input logic [2:0] ph, input logic [15:0] cyc, input string tag);
    q_tph.push_back(ph);
    q_tcyc.push_back(cyc);
    q_ttag.push_back(tag);
  endtask

  task automatic exp_cmd(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d,
                         input logic u, input string tag);
    q_cmd.push_back({u, c, a, d});
    q_ctag.push_back(tag);
  endtask

  task automatic ev(input logic sv, input logic [1:0] sk, input logic bv, input logic bio,
                    input logic yv, input logic [7:0] yd);
    @(negedge clk);
    sym_valid = sv; sym_kind = sk;
    bit_valid = bv; bit_io = bio;
    byte_valid = yv; byte_data = yd;
    @(negedge clk);
    sym_valid = 1'b0; bit_valid = 1'b0; byte_valid = 1'b0;
  endtask

  task automatic sym(input logic [1:0] k);
    ev(1'b1, k, 1'b0, 1'b0, 1'b0, 8'd0);
  endtask

  task automatic bitev(input logic v);
    ev(1'b0, 2'd0, 1'b1, v, 1'b0, 8'd0);
  endtask

  task automatic bytev(input logic [7:0] d);
    ev(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, d);
  endtask

  task automatic command(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d,
                         input logic u, input string tag);
    sym(2'd2);
    bytev(c);
    bytev(a);
    exp_cmd(c, a, d, u, tag);
    bytev(d);
  endtask

  // monitor: pop and compare on every strobe
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (txn_done) begin
        if (q_tph.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected txn_done actual phase %0d expected none", txn_phase);
        end else begin
          automatic logic [2:0] eph = q_tph.pop_front();
          automatic logic [15:0] ecy = q_tcyc.pop_front();
          automatic string tg = q_ttag.pop_front();
          chk({tg, " txn_phase"}, 32'(txn_phase), 32'(eph));
          if (eph == 3'd5) chk({tg, " proc_cycles"}, 32'(proc_cycles), 32'(ecy));
        end
      end
      if (cmd_done) begin
        if (q_cmd.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected cmd_done actual %0h expected none", cmd_ctrl);
        end else begin
          automatic logic [24:0] e = q_cmd.pop_front();
          automatic string tg = q_ctag.pop_front();
          chk({tg, " fields"}, 32'({cmd_unknown, cmd_ctrl, cmd_addr, cmd_data}), 32'(e));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 phase", 32'(phase), 0);
    chk("R11 strobes", 32'({txn_done, cmd_done}), 0);
    chk("R11 fields", 32'({cmd_ctrl, cmd_addr, cmd_data}), 0);
    chk("R11 proc_cycles", 32'(proc_cycles), 0);

    // R1 answer-to-reset
    sym(2'd0);
    chk("R1 enter ATR", 32'(phase), 1);
    bytev(8'h3B); bytev(8'h11); bytev(8'h22);
    chk("R1 still ATR", 32'(phase), 1);
    exp_txn(3'd1, 16'd0, "R1 atr done");
    bytev(8'h33);
    chk("R1 back idle", 32'(phase), 0);

    // R1 interrupt from idle: no ATR, no strobe
    sym(2'd1);
    chk("R1 intr idle", 32'(phase), 0);
    bytev(8'h44);
    chk("R1 intr no atr", 32'(phase), 0);

    // R9 interrupt flushes partial ATR
    sym(2'd0);
    bytev(8'h01);
    exp_txn(3'd1, 16'd0, "R9 intr flush atr");
    sym(2'd1);
    chk("R9 intr to idle", 32'(phase), 0);

    // R2 R3 R5 R6 fixed-length reads
    for (int i = 0; i < 2; i++) begin
      automatic logic [7:0] op = (i == 0) ? 8'h31 : 8'h34;
      command(op, 8'h05 + 8'(i), 8'hAA, 1'b0, "R2 fixed cmd");
      chk("R2 idle after cmd", 32'(phase), 0);
      sym(2'd3);
      chk("R4 stop to pend", 32'(phase), 3);
      bitev(1'b1);
      chk("R5 fixed to out", 32'(phase), 4);
      sym(2'd3);
      chk("R4 stop ignored in out", 32'(phase), 4);
      bytev(8'h10); bytev(8'h20); bytev(8'h30);
      chk("R6 out before last", 32'(phase), 4);
      exp_txn(3'd4, 16'd0, "R6 fixed out done");
      bytev(8'h40);
      chk("R6 idle after last", 32'(phase), 0);
    end

    // R3 open-ended read then start flushes it (R9)
    command(8'h30, 8'h10, 8'h00, 1'b0, "R3 open cmd");
    sym(2'd3);
    bitev(1'b0);
    chk("R5 open to out", 32'(phase), 4);
    for (int i = 0; i < 6; i++) bytev(8'(i));
    chk("R6 open stays out", 32'(phase), 4);
    exp_txn(3'd4, 16'd0, "R9 start flush out");
    sym(2'd2);
    chk("R9 new cmd same edge", 32'(phase), 2);
    bytev(8'h38);
    bytev(8'h07);
    exp_cmd(8'h38, 8'h07, 8'h5A, 1'b0, "R2 cmd after flush");
    bytev(8'h5A);

    // R7 processing with stop ignored
    sym(2'd3);
    bitev(1'b0);
    chk("R5 proc entered", 32'(phase), 5);
    bitev(1'b0); bitev(1'b0);
    sym(2'd3);
    chk("R4 stop ignored in proc", 32'(phase), 5);
    bitev(1'b0); bitev(1'b0);
    exp_txn(3'd5, 16'd6, "R7 proc count");
    bitev(1'b1);
    chk("R7 idle after proc", 32'(phase), 0);

    // R3 R7 other processing codes, varied lengths
    for (int i = 0; i < 3; i++) begin
      automatic logic [7:0] op = (i == 0) ? 8'h33 : (i == 1) ? 8'h39 : 8'h3C;
      command(op, 8'h02, 8'hC3, 1'b0, "R3 proc cmd");
      sym(2'd3);
      for (int k = 0; k < i; k++) bitev(1'b0);
      exp_txn(3'd5, 16'(i + 1), "R7 proc len");
      bitev(1'b1);
      chk("R7 proc idle", 32'(phase), 0);
    end

    // R3 unknown control byte, open-ended, reset flushes it
    command(8'h55, 8'h01, 8'h02, 1'b1, "R3 unknown cmd");
    sym(2'd3);
    bitev(1'b0);
    chk("R3 unknown to out", 32'(phase), 4);
    for (int i = 0; i < 5; i++) bytev(8'hE0);
    chk("R3 unknown open", 32'(phase), 4);
    exp_txn(3'd4, 16'd0, "R9 reset flush out");
    sym(2'd0);
    chk("R9 reset enters atr", 32'(phase), 1);
    // R10 bit beats byte in the same cycle
    ev(1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 8'h99);
    bytev(8'h01); bytev(8'h02); bytev(8'h03);
    chk("R10 byte dropped", 32'(phase), 1);
    exp_txn(3'd1, 16'd0, "R1 atr after priority");
    bytev(8'h04);

    // R10 symbol beats byte in the same cycle
    ev(1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 8'h31);
    bytev(8'h30); bytev(8'h01);
    exp_cmd(8'h30, 8'h01, 8'h02, 1'b0, "R10 sym over byte");
    bytev(8'h02);

    // R9 start flushes processing with partial count, then intr flushes cmd
    command(8'h33, 8'h00, 8'h00, 1'b0, "R2 proc cmd");
    sym(2'd3);
    bitev(1'b0); bitev(1'b0); bitev(1'b0);
    exp_txn(3'd5, 16'd3, "R9 start flush proc");
    sym(2'd2);
    chk("R9 cmd after proc flush", 32'(phase), 2);
    bytev(8'h31);
    exp_txn(3'd2, 16'd0, "R9 intr flush cmd");
    sym(2'd1);
    chk("R9 idle after cmd flush", 32'(phase), 0);

    // R8 saturation of the processing count
    command(8'h3C, 8'h08, 8'h09, 1'b0, "R2 sat cmd");
    sym(2'd3);
    @(negedge clk);
    bit_valid = 1'b1; bit_io = 1'b0;
    repeat (65540) @(negedge clk);
    chk("R8 still processing", 32'(phase), 5);
    exp_txn(3'd5, 16'hFFFF, "R8 saturated count");
    bit_io = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0; bit_io = 1'b0;
    @(negedge clk);
    chk("R8 proc_cycles held", 32'(proc_cycles), 32'hFFFF);

    repeat (4) @(negedge clk);
    chk("R9 no pending txn", 32'(q_tph.size()), 0);
    chk("R2 no pending cmd", 32'(q_cmd.size()), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule